// File: doc/BRIEF.md
# Interrupt Redirection to Message-Signalled Delivery

This block turns service requests on a set of interrupt pins (24 by default) into message-signalled interrupt writes. Each pin has a 64-bit redirection entry, supplied by a neighbouring register file. The block builds the message address and data word from that entry's fields and presents them on a valid/ready output.

The block owns two status bits per pin and reports them back to the register file: delivery status and remote IRR. Delivery status means a request is waiting. Remote IRR means a level-triggered interrupt is in service. An end-of-interrupt (EOI) broadcast carries a vector and clears remote IRR on every matching level-triggered entry.

Requests wait in per-pin latches. Among the eligible pins, the lowest-numbered pin is sent first.

Output back-pressure follows valid/ready rules:
- The block raises `msg_valid` only when it has a message.
- Once raised, `msg_valid`, `msg_addr_lo`, `msg_data` and `msg_pin` hold steady until the cycle in which `msg_ready` is high at a clock edge.
- The consumer may hold `msg_ready` low for any number of cycles. Pending requests keep waiting during that time.
- After a message is accepted, the output is idle for one cycle before the next message is loaded.

Top module: `msi_route`

## Requirements
- R1: The message address low word is `base_addr | dest<<12 | 1<<3 | dm<<2`. Here dest is all eight entry bits 63:56, in either destination mode, and dm is entry bit 11. `msg_addr_hi` is always zero.
- R2: The message data word has entry bit 15 (trigger, 1 = level) at bit 15 and the pin's remote IRR at bit 14. It has the entry's delivery mode (bits 10:8) at bits 10:8, and the vector (bits 7:0) at bits 7:0. All other bits are zero. All eight delivery-mode codes 0 to 7 pass through unchanged.
- R3: A request on a pin whose entry has bit 16 (mask) set is ignored. It creates no pending state, sets no delivery status and produces no message.
- R4: Among eligible pending pins, the lowest pin number is sent first.
- R5: `msg_valid` and the payload stay stable while `msg_ready` is low. A message is accepted at a clock edge with both `msg_valid` and `msg_ready` high.
- R6: When a message from a level-triggered pin is accepted, that pin's remote IRR becomes 1. Acceptance from an edge pin leaves remote IRR unchanged.
- R7: Delivery status (`dstat_o`) is set when a request arrives on an unmasked pin. It stays set until that pin's message is accepted. A new request in the acceptance cycle keeps it set, and repeated requests while pending merge into one message.
- R8: A level-triggered pin whose remote IRR is 1 is not sent. Its request stays pending until an EOI clears remote IRR.
- R9: An EOI clears remote IRR on every level-triggered entry whose vector equals `eoi_vec`. Entries with another vector, and edge entries, are unchanged.
- R10: If an EOI and a level acceptance hit the same pin in one cycle, remote IRR ends at 1.
- R11: After reset, `msg_valid`, `dstat_o` and `rirr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 32 | Message address base |
| entries | input | NPINS*64 | Redirection entries, pin i at bits i*64+63:i*64 |
| svc_req | input | NPINS | Per-pin service request, one cycle per request |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vec | input | 8 | EOI vector |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts message |
| msg_addr_lo | output | 32 | Message address low word |
| msg_addr_hi | output | 32 | Message address high word (zero) |
| msg_data | output | 32 | Message data word |
| msg_pin | output | $clog2(NPINS) | Pin that raised the message |
| dstat_o | output | NPINS | Delivery status per pin |
| rirr_o | output | NPINS | Remote IRR per pin |

## Verification
The assertions rely on a few assumptions about the inputs:
- The entries input is a plain registered value.
- The status bits 12 and 14 carried in that input are ignored.
- `eoi_vec` only matters while `eoi_valid` is high.

Stimulus changes entries only between clock edges. It drives sparse random requests, EOIs drawn from a small vector pool so that they often match, and random ready. Directed sequences reach the masked-pin, blocked-level, same-cycle EOI/acceptance and priority corners.

// File: rtl/msi_route_pkg.sv
package msi_route_pkg;

  localparam int ENT_W = 64;
  localparam logic ADDR_HINT = 1'b1;

  typedef struct packed {
    logic [7:0]  dest;
    logic [38:0] rsvd;
    logic        mask;
    logic        level;
    logic        rirr_ro;
    logic        polarity;
    logic        dstat_ro;
    logic        dest_logical;
    logic [2:0]  dmode;
    logic [7:0]  vec;
  } rte_t;

endpackage

// File: rtl/msi_pin_state.sv
module msi_pin_state (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       svc_i,
  input  logic       masked_i,
  input  logic       level_i,
  input  logic [7:0] vec_i,
  input  logic       eoi_valid_i,
  input  logic [7:0] eoi_vec_i,
  input  logic       accept_i,
  output logic       pend_o,
  output logic       rirr_o,
  output logic       elig_o
);

  logic pend_q, rirr_q;
  logic eoi_hit;

  assign eoi_hit = eoi_valid_i && (vec_i == eoi_vec_i) && level_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (svc_i && !masked_i) begin
      pend_q <= 1'b1;
    end else if (accept_i) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rirr_q <= 1'b0;
    end else if (accept_i && level_i) begin
      rirr_q <= 1'b1;
    end else if (eoi_hit) begin
      rirr_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign rirr_o = rirr_q;
  assign elig_o = pend_q && !masked_i && !(level_i && rirr_q);

  AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_i && masked_i && !pend_q) |=> !pend_q); // R3
  AST_LEVEL_SETS_IRR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && level_i) |=> rirr_q); // R6
  AST_SET_BEATS_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && level_i && eoi_hit) |=> rirr_q); // R10
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !accept_i) |=> !rirr_q); // R9
  AST_EDGE_KEEPS_IRR: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i) |=> (rirr_q == $past(rirr_q))); // R9

endmodule

// File: rtl/msi_prio_pick.sv
module msi_prio_pick #(
  parameter int N = 24,
  parameter int W = 5
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end

  always_comb begin
    if (any_o) begin
      AST_PICK_REQUESTED: assert (req_i[idx_o]); // R4
      AST_PICK_LOWEST: assert ((req_i & ((N'(1) << idx_o) - N'(1))) == '0); // R4
    end
  end

endmodule

// File: rtl/msi_msg_form.sv
module msi_msg_form
  import msi_route_pkg::*;
(
  input  logic [31:0] base_i,
  input  rte_t        ent_i,
  input  logic        rirr_i,
  output logic [31:0] addr_lo_o,
  output logic [31:0] data_o
);

  always_comb begin
    addr_lo_o = base_i
              | (32'(ent_i.dest) << 12)
              | (32'(ADDR_HINT) << 3)
              | (32'(ent_i.dest_logical) << 2);
    data_o = {16'h0000, ent_i.level, rirr_i, 3'b000, ent_i.dmode, ent_i.vec};
  end

endmodule

// File: rtl/msi_route.sv
module msi_route
  import msi_route_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int PW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [31:0]            base_addr,
  input  logic [NPINS*ENT_W-1:0] entries,
  input  logic [NPINS-1:0]       svc_req,
  input  logic                   eoi_valid,
  input  logic [7:0]             eoi_vec,
  output logic                   msg_valid,
  input  logic                   msg_ready,
  output logic [31:0]            msg_addr_lo,
  output logic [31:0]            msg_addr_hi,
  output logic [31:0]            msg_data,
  output logic [PW-1:0]          msg_pin,
  output logic [NPINS-1:0]       dstat_o,
  output logic [NPINS-1:0]       rirr_o
);

  rte_t             ent [NPINS];
  logic [NPINS-1:0] pend, rirr, elig, acc_vec;
  logic             pick_any;
  logic [PW-1:0]    pick_idx;
  rte_t             sel_ent;
  logic             sel_rirr;
  logic [31:0]      form_addr, form_data;
  logic             valid_q;
  logic [PW-1:0]    pin_q;
  logic [31:0]      addr_q, data_q;
  logic             accept;

  assign accept = valid_q && msg_ready;

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      acc_vec[i] = accept && (pin_q == PW'(i));
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign ent[g] = rte_t'(entries[g*ENT_W +: ENT_W]);
    msi_pin_state u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .svc_i      (svc_req[g]),
      .masked_i   (ent[g].mask),
      .level_i    (ent[g].level),
      .vec_i      (ent[g].vec),
      .eoi_valid_i(eoi_valid),
      .eoi_vec_i  (eoi_vec),
      .accept_i   (acc_vec[g]),
      .pend_o     (pend[g]),
      .rirr_o     (rirr[g]),
      .elig_o     (elig[g])
    );
  end

  msi_prio_pick #(.N(NPINS), .W(PW)) u_pick (
    .req_i(elig),
    .any_o(pick_any),
    .idx_o(pick_idx)
  );

  assign sel_ent  = ent[pick_idx];
  assign sel_rirr = rirr[pick_idx];

  msi_msg_form u_form (
    .base_i   (base_addr),
    .ent_i    (sel_ent),
    .rirr_i   (sel_rirr),
    .addr_lo_o(form_addr),
    .data_o   (form_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pin_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (!valid_q) begin
      if (pick_any) begin
        valid_q <= 1'b1;
        pin_q   <= pick_idx;
        addr_q  <= form_addr;
        data_q  <= form_data;
      end
    end else if (msg_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign msg_valid   = valid_q;
  assign msg_pin     = pin_q;
  assign msg_addr_lo = addr_q;
  assign msg_addr_hi = 32'h0;
  assign msg_data    = data_q;
  assign dstat_o     = pend;
  assign rirr_o      = rirr;

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid); // R5
  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> ($stable(msg_addr_lo) && $stable(msg_data) && $stable(msg_pin))); // R5
  AST_INFLIGHT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> pend[pin_q]); // R7
  AST_HINT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_addr_lo[3]); // R1
  AST_SINGLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_vec)); // R5

endmodule

// File: tb/sim_msi_route.sv
module sim_msi_route;
  localparam int NP = 24;
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] base_addr = 32'hFEE0_0000;
  logic [63:0] ent [NP];
  logic [NP*64-1:0] entries;
  logic [NP-1:0] svc_req = '0;
  logic eoi_valid = 1'b0;
  logic [7:0] eoi_vec = '0;
  logic msg_ready = 1'b0;
  logic msg_valid;
  logic [31:0] msg_addr_lo, msg_addr_hi, msg_data;
  logic [PW-1:0] msg_pin;
  logic [NP-1:0] dstat_o, rirr_o;

  int n_chk = 0;
  int n_bad = 0;

  logic m_valid;
  logic [PW-1:0] m_pin;
  logic [31:0] m_addr, m_data;
  logic [NP-1:0] m_pend, m_rirr;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NP; i++) entries[i*64 +: 64] = ent[i];
  end

  msi_route #(.NPINS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .entries(entries),
    .svc_req(svc_req), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr_lo(msg_addr_lo),
    .msg_addr_hi(msg_addr_hi), .msg_data(msg_data), .msg_pin(msg_pin),
    .dstat_o(dstat_o), .rirr_o(rirr_o)
  );

  function automatic logic [31:0] exp_addr(logic [31:0] b, logic [63:0] e);
    return b | (32'(e[63:56]) << 12) | 32'h8 | (32'(e[11]) << 2);
  endfunction

  function automatic logic [31:0] exp_data(logic [63:0] e, logic r);
    return (32'(e[15]) << 15) | (32'(r) << 14) | (32'(e[10:8]) << 8) | 32'(e[7:0]);
  endfunction

  function automatic logic [63:0] mk(logic [7:0] dest, logic msk, logic lvl,
                                     logic dm, logic [2:0] dmode, logic [7:0] vec);
    return {dest, 39'b0, msk, lvl, 3'b000, dm, dmode, vec};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic acc;
    logic [NP-1:0] elig, np, nr;
    int sel;
    acc = m_valid && msg_ready;
    sel = -1;
    for (int i = 0; i < NP; i++) begin
      elig[i] = m_pend[i] && !ent[i][16] && !(ent[i][15] && m_rirr[i]);
      np[i] = m_pend[i];
      nr[i] = m_rirr[i];
      if (svc_req[i] && !ent[i][16]) np[i] = 1'b1;
      else if (acc && m_pin == PW'(i)) np[i] = 1'b0;
      if (acc && m_pin == PW'(i) && ent[i][15]) nr[i] = 1'b1;
      else if (eoi_valid && ent[i][7:0] == eoi_vec && ent[i][15]) nr[i] = 1'b0;
    end
    for (int i = NP - 1; i >= 0; i--) if (elig[i]) sel = i;
    if (!m_valid) begin
      if (sel >= 0) begin
        m_valid = 1'b1;
        m_pin = PW'(sel);
        m_addr = exp_addr(base_addr, ent[sel]);
        m_data = exp_data(ent[sel], m_rirr[sel]);
      end
    end else if (acc) begin
      m_valid = 1'b0;
    end
    m_pend = np;
    m_rirr = nr;
  endtask

  task automatic compare();
    chk("R5 valid", 64'(msg_valid), 64'(m_valid));
    if (m_valid) begin
      chk("R4 pin", 64'(msg_pin), 64'(m_pin));
      chk("R1 addr_lo", 64'(msg_addr_lo), 64'(m_addr));
      chk("R1 addr_hi", 64'(msg_addr_hi), 64'h0);
      chk("R2 data", 64'(msg_data), 64'(m_data));
    end
    chk("R7 dstat", 64'(dstat_o), 64'(m_pend));
    chk("R6 rirr", 64'(rirr_o), 64'(m_rirr));
  endtask

  task automatic cyc(logic [NP-1:0] s, logic ev, logic [7:0] vv, logic r);
    svc_req = s; eoi_valid = ev; eoi_vec = vv; msg_ready = r;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < NP; i++) ent[i] = 64'h1_0000;
    m_valid = 1'b0; m_pin = '0; m_addr = '0; m_data = '0; m_pend = '0; m_rirr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R11 valid", 64'(msg_valid), 64'h0);
    chk("R11 dstat", 64'(dstat_o), 64'h0);
    chk("R11 rirr", 64'(rirr_o), 64'h0);

    // R1: full eight-bit destination, logical mode
    ent[3] = mk(8'hA5, 0, 0, 1, 3'd0, 8'h41);
    cyc(NP'(1) << 3, 0, 0, 0);
    cyc('0, 0, 0, 0);
    chk("R1 explicit", 64'(msg_addr_lo), 64'hFEEA500C);
    cyc('0, 0, 0, 1);
    chk("R7 cleared", 64'(dstat_o[3]), 64'h0);

    // R2: all delivery modes
    for (int d = 0; d < 8; d++) begin
      ent[5] = mk(8'h00, 0, 0, 0, 3'(d), 8'h50 + 8'(d));
      cyc(NP'(1) << 5, 0, 0, 0);
      cyc('0, 0, 0, 0);
      chk("R2 mode", 64'(msg_data), 64'((d << 8) | (8'h50 + d)));
      cyc('0, 0, 0, 1);
    end

    // R3: masked pin
    ent[7] = mk(8'h01, 1, 0, 0, 3'd0, 8'h70);
    cyc(NP'(1) << 7, 0, 0, 1);
    repeat (3) cyc('0, 0, 0, 1);
    chk("R3 no msg", 64'(msg_valid), 64'h0);
    chk("R3 no dstat", 64'(dstat_o[7]), 64'h0);

    // R4: priority
    ent[2] = mk(8'h02, 0, 0, 0, 3'd0, 8'h22);
    ent[9] = mk(8'h09, 0, 0, 0, 3'd0, 8'h22);
    cyc((NP'(1) << 9) | (NP'(1) << 2), 0, 0, 0);
    cyc('0, 0, 0, 0);
    chk("R4 first", 64'(msg_pin), 64'd2);
    cyc('0, 0, 0, 1);
    cyc('0, 0, 0, 0);
    chk("R4 second", 64'(msg_pin), 64'd9);
    cyc('0, 0, 0, 1);

    // R8, R9, R10: level pins
    ent[10] = mk(8'h0A, 0, 1, 0, 3'd0, 8'h60);
    ent[12] = mk(8'h0C, 0, 1, 0, 3'd0, 8'h61);
    cyc((NP'(1) << 10) | (NP'(1) << 12), 0, 0, 0);
    cyc('0, 0, 0, 0);
    cyc('0, 0, 0, 1);
    cyc('0, 0, 0, 0);
    cyc('0, 0, 0, 1);
    chk("R6 set", 64'(rirr_o[10]), 64'h1);
    cyc(NP'(1) << 10, 0, 0, 1);
    repeat (3) cyc('0, 0, 0, 1);
    chk("R8 blocked", 64'(msg_valid), 64'h0);
    chk("R8 pending", 64'(dstat_o[10]), 64'h1);
    cyc('0, 1, 8'h60, 1);
    chk("R9 cleared", 64'(rirr_o[10]), 64'h0);
    chk("R9 other vec", 64'(rirr_o[12]), 64'h1);
    cyc('0, 0, 0, 0);
    chk("R8 released", 64'(msg_pin), 64'd10);
    cyc('0, 1, 8'h60, 1);
    chk("R10 set wins", 64'(rirr_o[10]), 64'h1);
    cyc('0, 1, 8'h60, 0);
    cyc('0, 1, 8'h61, 0);
    for (int i = 0; i < NP; i++) ent[i] = 64'h1_0000;
    cyc('0, 0, 0, 1);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [NP-1:0] s;
      if (k % 200 == 0) begin
        for (int i = 0; i < NP; i++)
          ent[i] = mk(8'($urandom), ($urandom % 5) == 0, 1'($urandom), 1'($urandom),
                      3'($urandom), 8'h30 + 8'($urandom % 4));
      end
      for (int i = 0; i < NP; i++) s[i] = ($urandom % 16) == 0;
      cyc(s, ($urandom % 4) == 0, 8'h30 + 8'($urandom % 4), 1'($urandom));
    end

    summary();
    $finish;
  end

endmodule